// File: doc/BRIEF.md
# Four-Channel Gradient DAC Serialiser

This block takes timed value updates for four gradient channels and shifts them out over SPI to external DAC devices. A one-cycle strobe on a channel places the value on that channel's input into a single-entry pending slot. If a value arrives before the previous one has gone out, the new value replaces it, so the output always moves toward the most recent setting. The system clock divider sets the SPI bit rate, and a busy flag reports that work is still outstanding.

Two topologies are selected by `mode_shared`. With `mode_shared = 0`, each channel has its own SPI lane to an 18-bit single-channel converter, and the four lanes run at the same time. With `mode_shared = 1`, only lane 0 is used. It addresses a 16-bit quad converter, and the channels take turns under a round-robin arbiter. A busy channel can therefore take the whole bus while the idle ones use none of it. `mode_shared` may only change while `busy` is low.

Each lane has its own engine, a four-state machine. `ENG_IDLE` moves to `ENG_LOW` on a start. `ENG_LOW` moves to `ENG_HIGH` when a half period has elapsed. `ENG_HIGH` returns to `ENG_LOW` when a half period has elapsed and bits remain, or moves to `ENG_GAP` after the last bit. `ENG_GAP` returns to `ENG_IDLE` once the chip-select gap has elapsed.

Top module: `grad_dac_serialiser`

## Requirements
- R1: While reset is asserted, all chip-selects are high, all SCLK and MOSI lines are low, and `busy` is low.
- R2: In per-lane mode, channel i is sent on lane i as a 24-bit frame: command nibble 4'b0001, then the 18-bit value MSB first, then two zero bits. Lanes with pending values start in the same cycle.
- R3: In shared mode, every frame goes out on lane 0 as 24 bits: the prefix 6'b000100, then the 2-bit channel index, then bits [15:0] of the value, MSB first. Lanes 1 to 3 stay idle, with CS high and SCLK low.
- R4: SCLK idles low, and MOSI is stable while SCLK is high. Each SCLK half period lasts `clk_div`+1 system clocks, so CS is low for 48*(`clk_div`+1) clocks. The divider is captured when a frame starts, and a change during the frame has no effect on it.
- R5: Between two frames on a lane, CS stays high for at least two system clocks. When a value is already pending, the next frame starts 48*(d+1)+3 clocks after the previous one started.
- R6: A new strobe replaces a channel's unsent pending value. A frame already in flight is not affected, and a strobe in the same cycle that a value is taken leaves the new value pending.
- R7: In shared mode, the search for the next channel starts just after the last channel served. After reset, the last channel served is taken to be channel 3.
- R8: In shared mode, a single channel that is updated repeatedly gets back-to-back frames at the same period as in R5. That is four times the per-channel rate seen when all four channels are active.
- R9: `busy` is high from the clock after a strobe until no value is pending and every lane has finished its chip-select gap. It falls two clocks after the last CS rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_shared | input | 1 | 0: four parallel lanes; 1: one shared bus on lane 0 |
| clk_div | input | DIV_W | SCLK half period, minus one, in system clocks |
| upd_stb | input | 4 | Per-channel update strobes |
| upd_val | input | 72 | Per-channel 18-bit values, channel i in bits [18i+17:18i] |
| spi_sclk | output | 4 | SPI clock per lane |
| spi_cs_n | output | 4 | Active-low chip-select per lane |
| spi_mosi | output | 4 | Serial data per lane |
| busy | output | 1 | Pending or in-flight work exists |

## Verification
The hardest situations to reach from the ports are the replacement of a pending value while another frame is on the wire, and back-to-back frames in shared mode, where one channel owns the bus. The bench reaches the first by strobing one channel on three consecutive clocks, so that the first value is taken and the third replaces the second before it is sent. It reaches the second by issuing each new strobe only after the bench's SPI receiver has seen the previous frame's chip-select fall. The round-robin order is checked against a pointer kept by the bench over random channel subsets.

// File: rtl/gdac_ser_pkg.sv
package gdac_ser_pkg;
    localparam int NUM_CH        = 4;
    localparam int CH_IDX_W      = $clog2(NUM_CH);
    localparam int LANE_DATA_W   = 18;
    localparam int SHARED_DATA_W = 16;
    localparam int FRAME_W       = 24;
    localparam int LANE_CMD_W    = 4;
    localparam int SHARED_CMD_W  = FRAME_W - CH_IDX_W - SHARED_DATA_W;
    localparam int LANE_PAD_W    = FRAME_W - LANE_CMD_W - LANE_DATA_W;
    localparam logic [LANE_CMD_W-1:0]   LANE_CMD   = 4'b0001;
    localparam logic [SHARED_CMD_W-1:0] SHARED_CMD = 6'b000100;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_LOW  = 2'd1,
        ENG_HIGH = 2'd2,
        ENG_GAP  = 2'd3
    } eng_state_t;

    function automatic logic [FRAME_W-1:0] lane_frame(input logic [LANE_DATA_W-1:0] v);
        return {LANE_CMD, v, {LANE_PAD_W{1'b0}}};
    endfunction

    function automatic logic [FRAME_W-1:0] shared_frame(input logic [CH_IDX_W-1:0] ch,
                                                        input logic [SHARED_DATA_W-1:0] v);
        return {SHARED_CMD, ch, v};
    endfunction
endpackage

// File: rtl/gdac_update_store.sv
module gdac_update_store #(
    parameter int NCH = 4,
    parameter int DW  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    stb,
    input  logic [NCH*DW-1:0] new_val,
    input  logic [NCH-1:0]    take,
    output logic [NCH-1:0]    pend,
    output logic [NCH*DW-1:0] pend_val
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend     <= '0;
            pend_val <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (stb[i]) begin
                    pend[i]              <= 1'b1;
                    pend_val[i*DW +: DW] <= new_val[i*DW +: DW];
                end else if (take[i]) begin
                    pend[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/gdac_rr_arbiter.sv
module gdac_rr_arbiter #(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic           adv,
    output logic           gnt_vld,
    output logic [IW-1:0]  gnt_idx
);
    logic [IW-1:0] last_q;

    always_comb begin
        int unsigned j;
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int k = NCH; k >= 1; k--) begin
            j = (int'(last_q) + k) % NCH;
            if (req[j]) begin
                gnt_vld = 1'b1;
                gnt_idx = IW'(j);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= IW'(NCH - 1);
        end else if (adv) begin
            last_q <= gnt_idx;
        end
    end
endmodule

// File: rtl/gdac_spi_engine.sv
module gdac_spi_engine import gdac_ser_pkg::*; #(
    parameter int FW      = 24,
    parameter int DIV_W   = 8,
    parameter int GAP_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [FW-1:0]    frame,
    input  logic [DIV_W-1:0] half_div,
    output logic             idle,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi
);
    localparam int BIT_W = $clog2(FW);

    eng_state_t        state, nxt;
    logic [DIV_W-1:0]  cnt;
    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bitcnt;
    logic [FW-1:0]     shreg;
    logic              half_done, gap_done, last_bit;

    assign half_done = (cnt == div_q);
    assign gap_done  = (cnt == DIV_W'(GAP_CYC - 1));
    assign last_bit  = (bitcnt == BIT_W'(FW - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ENG_IDLE: if (start)     nxt = ENG_LOW;
            ENG_LOW:  if (half_done) nxt = ENG_HIGH;
            ENG_HIGH: if (half_done) nxt = last_bit ? ENG_GAP : ENG_LOW;
            ENG_GAP:  if (gap_done)  nxt = ENG_IDLE;
        endcase
    end

    // datapath: shifter, bit and period counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            div_q  <= '0;
            bitcnt <= '0;
            shreg  <= '0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (start) begin
                        shreg  <= frame;
                        div_q  <= half_div;
                        cnt    <= '0;
                        bitcnt <= '0;
                    end
                end
                ENG_LOW: begin
                    cnt <= half_done ? '0 : cnt + 1'b1;
                end
                ENG_HIGH: begin
                    if (half_done) begin
                        cnt <= '0;
                        if (!last_bit) begin
                            shreg  <= {shreg[FW-2:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ENG_GAP: begin
                    cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        idle = 1'b0;
        sclk = 1'b0;
        cs_n = 1'b1;
        mosi = 1'b0;
        unique case (state)
            ENG_IDLE: idle = 1'b1;
            ENG_LOW: begin
                cs_n = 1'b0;
                mosi = shreg[FW-1];
            end
            ENG_HIGH: begin
                cs_n = 1'b0;
                sclk = 1'b1;
                mosi = shreg[FW-1];
            end
            ENG_GAP: ;
        endcase
    end
endmodule

// File: rtl/grad_dac_serialiser.sv
module grad_dac_serialiser import gdac_ser_pkg::*; #(
    parameter int DIV_W   = 8,
    parameter int GAP_CYC = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode_shared,
    input  logic [DIV_W-1:0]              clk_div,
    input  logic [NUM_CH-1:0]             upd_stb,
    input  logic [NUM_CH*LANE_DATA_W-1:0] upd_val,
    output logic [NUM_CH-1:0]             spi_sclk,
    output logic [NUM_CH-1:0]             spi_cs_n,
    output logic [NUM_CH-1:0]             spi_mosi,
    output logic                          busy
);
    logic [NUM_CH-1:0]             pend, take, eng_start, eng_idle, arb_req;
    logic [NUM_CH*LANE_DATA_W-1:0] pend_val;
    logic [FRAME_W-1:0]            eng_frame [NUM_CH];
    logic                          arb_vld, arb_adv;
    logic [CH_IDX_W-1:0]           arb_idx;

    gdac_update_store #(.NCH(NUM_CH), .DW(LANE_DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (upd_stb),
        .new_val  (upd_val),
        .take     (take),
        .pend     (pend),
        .pend_val (pend_val)
    );

    assign arb_req = mode_shared ? pend : '0;

    gdac_rr_arbiter #(.NCH(NUM_CH), .IW(CH_IDX_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (arb_req),
        .adv     (arb_adv),
        .gnt_vld (arb_vld),
        .gnt_idx (arb_idx)
    );

    // topology selection: lane i serves channel i, or lane 0 serves all
    always_comb begin
        take      = '0;
        eng_start = '0;
        arb_adv   = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            eng_frame[i] = lane_frame(pend_val[i*LANE_DATA_W +: LANE_DATA_W]);
        end
        if (mode_shared) begin
            arb_adv       = arb_vld & eng_idle[0];
            eng_start[0]  = arb_adv;
            eng_frame[0]  = shared_frame(arb_idx,
                                pend_val[arb_idx*LANE_DATA_W +: SHARED_DATA_W]);
            take[arb_idx] = arb_adv;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                eng_start[i] = pend[i] & eng_idle[i];
                take[i]      = eng_start[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        gdac_spi_engine #(.FW(FRAME_W), .DIV_W(DIV_W), .GAP_CYC(GAP_CYC)) u_eng (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (eng_start[g]),
            .frame    (eng_frame[g]),
            .half_div (clk_div),
            .idle     (eng_idle[g]),
            .sclk     (spi_sclk[g]),
            .cs_n     (spi_cs_n[g]),
            .mosi     (spi_mosi[g])
        );
    end

    assign busy = (|pend) | ~(&eng_idle);
endmodule

// File: rtl/gdac_ser_checks.sv
module gdac_ser_checks import gdac_ser_pkg::*; (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_shared,
    input logic [NUM_CH-1:0] upd_stb,
    input logic [NUM_CH-1:0] spi_sclk,
    input logic [NUM_CH-1:0] spi_cs_n,
    input logic [NUM_CH-1:0] spi_mosi,
    input logic              busy
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane_chk
        p_sclk_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
            spi_sclk[g] |-> !spi_cs_n[g]);
        p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (spi_sclk[g] && $past(spi_sclk[g])) |-> $stable(spi_mosi[g]));
        p_cs_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(spi_cs_n[g]) |=> spi_cs_n[g]);
        p_busy_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !spi_cs_n[g] |-> busy);
    end

    p_shared_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_shared |-> (spi_cs_n[NUM_CH-1:1] == '1 && spi_sclk[NUM_CH-1:1] == '0));

    p_strobe_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_stb) |=> busy);
endmodule

bind grad_dac_serialiser gdac_ser_checks u_checks (.*);

// File: tb/tb_grad_dac_serialiser.sv
`timescale 1ns/1ps
module tb_grad_dac_serialiser;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_shared;
    logic [7:0]  clk_div;
    logic [3:0]  upd_stb;
    logic [71:0] upd_val;
    logic [3:0]  spi_sclk, spi_cs_n, spi_mosi;
    logic        busy;

    grad_dac_serialiser dut (
        .clk(clk), .rst_n(rst_n), .mode_shared(mode_shared), .clk_div(clk_div),
        .upd_stb(upd_stb), .upd_val(upd_val), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .busy(busy)
    );

    always #4 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    // SPI receiver model per lane
    logic [23:0] cf  [4][64];
    int          cb  [4][64];
    int          cs0 [4][64];
    int          ce  [4][64];
    int          cl  [4][64];
    int          cn  [4];
    int          fn  [4];
    logic [23:0] wsh [4];
    int          wb  [4], wl [4], ws [4];
    logic [3:0]  prev_cs = 4'hF;
    logic [3:0]  prev_sclk = 4'h0;

    logic [17:0] tv [4];

    always @(negedge clk) begin
        cyc = cyc + 1;
        for (int l = 0; l < 4; l++) begin
            if (prev_cs[l] && !spi_cs_n[l]) begin
                wsh[l] = '0; wb[l] = 0; wl[l] = 0; ws[l] = cyc; fn[l]++;
            end
            if (!spi_cs_n[l]) begin
                wl[l]++;
                if (spi_sclk[l] && !prev_sclk[l]) begin
                    wsh[l] = {wsh[l][22:0], spi_mosi[l]};
                    wb[l]++;
                end
            end
            if (!prev_cs[l] && spi_cs_n[l]) begin
                if (cn[l] < 64) begin
                    cf[l][cn[l]]  = wsh[l];
                    cb[l][cn[l]]  = wb[l];
                    cs0[l][cn[l]] = ws[l];
                    ce[l][cn[l]]  = cyc;
                    cl[l][cn[l]]  = wl[l];
                end
                cn[l]++;
            end
        end
        prev_cs   = spi_cs_n;
        prev_sclk = spi_sclk;
    end

    function automatic logic [23:0] exp_lane(input logic [17:0] v);
        return {4'b0001, v, 2'b00};
    endfunction

    function automatic logic [23:0] exp_shared(input int ch, input logic [17:0] v);
        return {6'b000100, 2'(ch), v[15:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_caps();
        for (int l = 0; l < 4; l++) begin cn[l] = 0; fn[l] = 0; end
    endtask

    task automatic do_strobe(input logic [3:0] m);
        for (int c = 0; c < 4; c++) if (m[c]) upd_val[c*18 +: 18] = tv[c];
        upd_stb = m;
        @(negedge clk); #1;
        upd_stb = '0;
    endtask

    task automatic wait_idle(output int t);
        int guard;
        guard = 0;
        while (busy && guard < 20000) begin
            @(negedge clk); #1;
            guard++;
        end
        chk(guard < 20000, "R9 idle timeout", guard, 0);
        t = cyc;
    endtask

    task automatic chk_frame(input int l, input int idx, input logic [23:0] exp,
                             input int d, input string req);
        chk(cf[l][idx] == exp, req, cf[l][idx], exp);
        chk(cb[l][idx] == 24, {req, " bits"}, cb[l][idx], 24);
        chk(cl[l][idx] == 48 * (d + 1), "R4 cs low length", cl[l][idx], 48 * (d + 1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int t, d, last, k, guard;
        logic [3:0] m;
        logic [17:0] vv [4];
        int order [4];
        int no;
        void'($urandom(32'h5EED_0042));
        for (int l = 0; l < 4; l++) begin cn[l] = 0; fn[l] = 0; end
        rst_n = 1'b0; mode_shared = 1'b0; clk_div = 8'd1; upd_stb = '0; upd_val = '0;
        repeat (3) @(negedge clk); #1;
        // R1 reset state
        chk(spi_cs_n == 4'hF, "R1 cs_n", spi_cs_n, 4'hF);
        chk(spi_sclk == 4'h0, "R1 sclk", spi_sclk, 0);
        chk(spi_mosi == 4'h0, "R1 mosi", spi_mosi, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R2 four lanes in parallel, R4 divider captured, R9 busy timing
        clear_caps();
        for (int c = 0; c < 4; c++) tv[c] = 18'($urandom);
        do_strobe(4'hF);
        chk(busy == 1'b1, "R9 busy after strobe", busy, 1);
        repeat (10) @(negedge clk); #1;
        clk_div = 8'd3;
        wait_idle(t);
        clk_div = 8'd1;
        for (int l = 0; l < 4; l++) begin
            chk(cn[l] == 1, "R2 frame count", cn[l], 1);
            chk_frame(l, 0, exp_lane(tv[l]), 1, "R2 lane frame");
            chk(cs0[l][0] == cs0[0][0], "R2 lanes parallel", cs0[l][0], cs0[0][0]);
        end
        chk(t == ce[0][0] + 2, "R9 busy fall", t, ce[0][0] + 2);

        // R2/R4 random lane subsets and dividers
        for (int it = 0; it < 20; it++) begin
            m = 4'($urandom_range(1, 15));
            d = $urandom_range(0, 3);
            clk_div = 8'(d);
            clear_caps();
            for (int c = 0; c < 4; c++) tv[c] = 18'($urandom);
            do_strobe(m);
            wait_idle(t);
            for (int l = 0; l < 4; l++) begin
                chk(cn[l] == int'(m[l]), "R2 random count", cn[l], m[l]);
                if (m[l]) chk_frame(l, 0, exp_lane(tv[l]), d, "R2 random frame");
            end
        end

        // R6 overwrite of pending value, R5 back-to-back period and gap
        clk_div = 8'd2;
        clear_caps();
        tv[1] = 18'h2A5A5; vv[0] = tv[1]; do_strobe(4'b0010);
        tv[1] = 18'h11111;                do_strobe(4'b0010);
        tv[1] = 18'h3C3C3; vv[1] = tv[1]; do_strobe(4'b0010);
        wait_idle(t);
        chk(cn[1] == 2, "R6 frame count", cn[1], 2);
        chk_frame(1, 0, exp_lane(vv[0]), 2, "R6 in-flight value");
        chk_frame(1, 1, exp_lane(vv[1]), 2, "R6 newest value");
        chk(cs0[1][1] - cs0[1][0] == 48 * 3 + 3, "R5 period", cs0[1][1] - cs0[1][0], 48 * 3 + 3);
        chk(cs0[1][1] - ce[1][0] >= 2, "R5 cs gap", cs0[1][1] - ce[1][0], 2);

        // R3 shared bus, R7 order after reset
        mode_shared = 1'b1;
        clk_div = 8'd0;
        clear_caps();
        for (int c = 0; c < 4; c++) tv[c] = 18'($urandom);
        do_strobe(4'hF);
        wait_idle(t);
        chk(cn[0] == 4, "R3 shared count", cn[0], 4);
        for (int c = 0; c < 4; c++) chk_frame(0, c, exp_shared(c, tv[c]), 0, "R7 reset order");
        for (int l = 1; l < 4; l++) chk(cn[l] == 0, "R3 idle lanes", cn[l], 0);
        last = 3;

        // R7 pointer follows last served
        clear_caps();
        tv[2] = 18'($urandom);
        do_strobe(4'b0100);
        wait_idle(t);
        chk_frame(0, 0, exp_shared(2, tv[2]), 0, "R3 single shared");
        clear_caps();
        for (int c = 0; c < 4; c++) tv[c] = 18'($urandom);
        do_strobe(4'b1011);
        wait_idle(t);
        chk(cn[0] == 3, "R7 count", cn[0], 3);
        chk_frame(0, 0, exp_shared(3, tv[3]), 0, "R7 after ch2 first");
        chk_frame(0, 1, exp_shared(0, tv[0]), 0, "R7 after ch2 second");
        chk_frame(0, 2, exp_shared(1, tv[1]), 0, "R7 after ch2 third");
        last = 1;

        // R7 random subsets against bench pointer
        for (int it = 0; it < 15; it++) begin
            m = 4'($urandom_range(1, 15));
            clear_caps();
            for (int c = 0; c < 4; c++) tv[c] = 18'($urandom);
            no = 0;
            for (int s = 1; s <= 4; s++) begin
                k = (last + s) % 4;
                if (m[k]) begin order[no] = k; no++; end
            end
            do_strobe(m);
            wait_idle(t);
            chk(cn[0] == no, "R7 random count", cn[0], no);
            for (int q = 0; q < no; q++)
                chk_frame(0, q, exp_shared(order[q], tv[order[q]]), 0, "R7 random order");
            last = order[no - 1];
        end

        // R8 one channel owns the shared bus
        clear_caps();
        for (int q = 0; q < 4; q++) begin
            tv[2] = 18'($urandom);
            vv[q] = tv[2];
            do_strobe(4'b0100);
            guard = 0;
            while (fn[0] < q + 1 && guard < 1000) begin
                @(negedge clk); #1;
                guard++;
            end
        end
        wait_idle(t);
        chk(cn[0] == 4, "R8 frame count", cn[0], 4);
        for (int q = 0; q < 4; q++) chk_frame(0, q, exp_shared(2, vv[q]), 0, "R8 frame");
        for (int q = 1; q < 4; q++)
            chk(cs0[0][q] - cs0[0][q-1] == 51, "R8 back-to-back period",
                cs0[0][q] - cs0[0][q-1], 51);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule